// File: doc/BRIEF.md
# Latched Rail Fault Supervisor

This block decides when a multi-rail display power supply must shut down after its start-up ordering has finished. It watches four rail undervoltage flags (boost, positive gate rail, negative gate rail, logic rail) and two flags that report an open-drain control pin still stuck high. Each of these six sources is a timed fault: it starts one shared counter, and the supply is shut down only if the fault is still present when the counter reaches its limit. If the fault disappears first, the counter drops back to zero and operation continues. Three other sources act at once, with no counter: the sequencing-capacitor pin fault, the reference fault and over-temperature.

A shutdown is held in one of two latches. A fault that does not involve the logic rail is held in the enable latch, which clears when the enable input goes low. A logic-rail fault is held in the supply latch, which only a supply-valid drop clears. Only the supply latch turns off the logic rail. Monitoring needs the start-up-done input to be high. The counter length is a parameter in clock cycles, so the nominal 50 ms timeout becomes a count of the system clock.

Top module: `rail_fault_guard`

## Requirements
- R1: While `seq_done`, `en` and `supply_ok` are high and no latch is set, any one of `dly_fault`, `ref_fault` or `ot_fault` sets the enable latch at the next clock edge. There is no counting delay, and `shut_main` goes high.
- R2: A timed fault that is present for TMO_CYC consecutive clock edges sets a latch on the TMO_CYC-th edge. At that edge the counter returns to zero.
- R3: If a timed fault disappears before the limit, `tmr_value` is 0 after the next edge and no latch is set. The next episode counts again from 1. The counter never exceeds TMO_CYC-1.
- R4: While `seq_done` is low, every fault input is ignored: `tmr_value` stays 0 and no latch is set.
- R5: The enable latch is cleared on every edge at which `en` is low. `shut_main` is high whenever `en` is low or either latch is set.
- R6: Rail bit LOGIC_IDX (bit 3 by default) is the logic rail. Its timeout sets the supply latch, which drives both `shut_logic` and `shut_main`. A low `en` neither clears this latch nor, on its own, raises `shut_logic`.
- R7: On an edge where `supply_ok` is low, both latches and the counter clear.
- R8: Overlapping timed faults share one counter, which runs while any of them is present. If the logic rail faulted at any point in the episode, the shutdown goes to the supply latch.
- R9: `fault_latched[0]` reports the enable latch and `fault_latched[1]` reports the supply latch.
- R10: Rail bits other than LOGIC_IDX and both `od_stuck` bits are timed faults that load the enable latch. While `en` is low they are ignored, but the logic rail is still monitored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| supply_ok | input | 1 | input supply valid; low clears all state |
| en | input | 1 | enable pin level |
| seq_done | input | 1 | start-up ordering finished |
| uv_flags | input | NUM_RAILS | undervoltage per rail; bit 0 boost, 1 positive, 2 negative, LOGIC_IDX logic |
| od_stuck | input | NUM_OD | open-drain pin not pulled low after start-up |
| ref_fault | input | 1 | reference fault, immediate |
| ot_fault | input | 1 | over-temperature, immediate |
| dly_fault | input | 1 | sequencing-capacitor pin fault, immediate |
| shut_main | output | 1 | shut down boost and gate rails |
| shut_logic | output | 1 | shut down logic rail |
| tmr_value | output | clog2(TMO_CYC) | timeout counter |
| fault_latched | output | 2 | {supply latch, enable latch} |

## Verification
The bench sweeps every timed source across fault durations from one cycle up to one cycle past the limit. An off-by-one counter would latch one cycle early or late, and a counter that does not clear would latch on a short glitch. It overlaps a brief logic-rail pulse with a long boost fault to catch a design that takes the latch type from the last fault only, and it restarts an episode to catch a counter that carries its value over. It also drops the enable input after each latch: a design that clears the logic latch on enable, or that lets enable switch off the logic rail, shows the wrong `shut_logic`.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
   typedef enum logic [1:0] {
      LK_NONE   = 2'b00,
      LK_ENABLE = 2'b01,
      LK_SUPPLY = 2'b10
   } latch_kind_t;
endpackage

// File: rtl/fsup_classify.sv
module fsup_classify #(
   parameter int NUM_RAILS = 4,
   parameter int LOGIC_IDX = 3,
   parameter int NUM_OD    = 2
) (
   input  logic                 seq_done,
   input  logic                 en,
   input  logic                 hold_main,
   input  logic                 hold_logic,
   input  logic [NUM_RAILS-1:0] uv_flags,
   input  logic [NUM_OD-1:0]    od_stuck,
   input  logic                 ref_fault,
   input  logic                 ot_fault,
   input  logic                 dly_fault,
   output logic                 imm_hit,
   output logic                 timed_hit,
   output logic                 timed_logic
);
   logic main_watch;
   logic logic_watch;
   logic [NUM_RAILS-1:0] rail_gated;
   logic [NUM_OD-1:0]    od_gated;

   assign main_watch  = seq_done & en & ~hold_main;
   assign logic_watch = seq_done & ~hold_logic;

   for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
      if (i == LOGIC_IDX) begin : g_logic
         assign rail_gated[i] = uv_flags[i] & logic_watch;
      end else begin : g_main
         assign rail_gated[i] = uv_flags[i] & main_watch;
      end
   end

   for (genvar j = 0; j < NUM_OD; j++) begin : g_od
      assign od_gated[j] = od_stuck[j] & main_watch;
   end

   assign imm_hit     = main_watch & (ref_fault | ot_fault | dly_fault);
   assign timed_hit   = (|rail_gated) | (|od_gated);
   assign timed_logic = rail_gated[LOGIC_IDX];
endmodule

// File: rtl/fsup_timer.sv
module fsup_timer #(
   parameter int TMO_CYC = 5_000_000,
   localparam int TW     = $clog2(TMO_CYC)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          timed_hit,
   input  logic          timed_logic,
   output logic [TW-1:0] cnt,
   output logic          fire,
   output logic          fire_logic
);
   localparam logic [TW-1:0] LAST = TW'(TMO_CYC - 1);

   logic ep_logic;

   assign fire       = timed_hit & (cnt == LAST);
   assign fire_logic = fire & (ep_logic | timed_logic);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         ep_logic <= 1'b0;
      end else if (clr || !timed_hit || fire) begin
         cnt      <= '0;
         ep_logic <= 1'b0;
      end else begin
         cnt      <= cnt + 1'b1;
         ep_logic <= ep_logic | timed_logic;
      end
   end

   AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= LAST); // R3
   AST_TMR_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !timed_hit |=> cnt == '0); // R3
   AST_FIRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n) fire |=> cnt == '0); // R2
   AST_CLR_TMR: assert property (@(posedge clk) disable iff (!rst_n) clr |=> cnt == '0); // R7
endmodule

// File: rtl/fsup_latch.sv
module fsup_latch
   import fsup_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        supply_ok,
   input  logic        en,
   input  logic        imm_hit,
   input  logic        fire,
   input  logic        fire_logic,
   output latch_kind_t state
);
   logic lat_en;
   logic lat_sup;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_en  <= 1'b0;
         lat_sup <= 1'b0;
      end else if (!supply_ok) begin
         lat_en  <= 1'b0;
         lat_sup <= 1'b0;
      end else begin
         lat_sup <= lat_sup | fire_logic;
         if (!en) lat_en <= 1'b0;
         else     lat_en <= lat_en | imm_hit | (fire & ~fire_logic);
      end
   end

   assign state = latch_kind_t'({lat_sup, lat_en});

   AST_IMM_SHUT: assert property (@(posedge clk) disable iff (!rst_n) (supply_ok && en && imm_hit) |=> lat_en); // R1
   AST_EN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (supply_ok && !en) |=> !lat_en); // R5
   AST_LOGIC_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (supply_ok && lat_sup) |=> lat_sup); // R6
   AST_SUPPLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) !supply_ok |=> (!lat_en && !lat_sup)); // R7
endmodule

// File: rtl/rail_fault_guard.sv
module rail_fault_guard
   import fsup_pkg::*;
#(
   parameter int NUM_RAILS = 4,
   parameter int LOGIC_IDX = 3,
   parameter int NUM_OD    = 2,
   parameter int TMO_CYC   = 5_000_000
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         supply_ok,
   input  logic                         en,
   input  logic                         seq_done,
   input  logic [NUM_RAILS-1:0]         uv_flags,
   input  logic [NUM_OD-1:0]            od_stuck,
   input  logic                         ref_fault,
   input  logic                         ot_fault,
   input  logic                         dly_fault,
   output logic                         shut_main,
   output logic                         shut_logic,
   output logic [$clog2(TMO_CYC)-1:0]   tmr_value,
   output logic [1:0]                   fault_latched
);
   localparam int TW = $clog2(TMO_CYC);

   if (TMO_CYC < 2) begin : g_bad_tmo
      $error("TMO_CYC must be at least 2");
   end
   if (LOGIC_IDX < 0 || LOGIC_IDX >= NUM_RAILS) begin : g_bad_idx
      $error("LOGIC_IDX out of range");
   end
   if (NUM_OD < 1) begin : g_bad_od
      $error("NUM_OD must be at least 1");
   end

   latch_kind_t  kind;
   logic         imm_hit;
   logic         timed_hit;
   logic         timed_logic;
   logic         fire;
   logic         fire_logic;
   logic [TW-1:0] cnt;

   fsup_classify #(
      .NUM_RAILS (NUM_RAILS),
      .LOGIC_IDX (LOGIC_IDX),
      .NUM_OD    (NUM_OD)
   ) i_classify (
      .seq_done    (seq_done),
      .en          (en),
      .hold_main   (kind != LK_NONE),
      .hold_logic  (kind[1]),
      .uv_flags    (uv_flags),
      .od_stuck    (od_stuck),
      .ref_fault   (ref_fault),
      .ot_fault    (ot_fault),
      .dly_fault   (dly_fault),
      .imm_hit     (imm_hit),
      .timed_hit   (timed_hit),
      .timed_logic (timed_logic)
   );

   fsup_timer #(
      .TMO_CYC (TMO_CYC)
   ) i_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (!supply_ok),
      .timed_hit   (timed_hit),
      .timed_logic (timed_logic),
      .cnt         (cnt),
      .fire        (fire),
      .fire_logic  (fire_logic)
   );

   fsup_latch i_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .supply_ok  (supply_ok),
      .en         (en),
      .imm_hit    (imm_hit),
      .fire       (fire),
      .fire_logic (fire_logic),
      .state      (kind)
   );

   assign tmr_value     = cnt;
   assign fault_latched = kind;
   assign shut_logic    = kind[1];
   assign shut_main     = ~en | kind[0] | kind[1];

   AST_NO_MON_BEFORE_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      (!seq_done && supply_ok && fault_latched == 2'b00) |=> fault_latched == 2'b00); // R4
   AST_EN_SPARES_LOGIC: assert property (@(posedge clk) disable iff (!rst_n)
      (supply_ok && !en && !shut_logic && !uv_flags[LOGIC_IDX]) |=> !shut_logic); // R6
endmodule

// File: tb/test_rail_fault_guard.sv
module test_rail_fault_guard;
   localparam int TMO = 6;
   localparam int TW  = $clog2(TMO);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic supply_ok = 1'b0;
   logic en = 1'b0;
   logic seq_done = 1'b0;
   logic [3:0] uv_flags = '0;
   logic [1:0] od_stuck = '0;
   logic ref_fault = 1'b0;
   logic ot_fault = 1'b0;
   logic dly_fault = 1'b0;
   logic shut_main;
   logic shut_logic;
   logic [TW-1:0] tmr_value;
   logic [1:0] fault_latched;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #5 clk = ~clk;

   rail_fault_guard #(
      .NUM_RAILS (4),
      .LOGIC_IDX (3),
      .NUM_OD    (2),
      .TMO_CYC   (TMO)
   ) i_rail_fault_guard (
      .clk           (clk),
      .rst_n         (rst_n),
      .supply_ok     (supply_ok),
      .en            (en),
      .seq_done      (seq_done),
      .uv_flags      (uv_flags),
      .od_stuck      (od_stuck),
      .ref_fault     (ref_fault),
      .ot_fault      (ot_fault),
      .dly_fault     (dly_fault),
      .shut_main     (shut_main),
      .shut_logic    (shut_logic),
      .tmr_value     (tmr_value),
      .fault_latched (fault_latched)
   );

   task automatic step(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_inputs();
      uv_flags = '0; od_stuck = '0;
      ref_fault = 0; ot_fault = 0; dly_fault = 0;
   endtask

   task automatic restart();
      clear_inputs();
      supply_ok = 0;
      step(1);
      supply_ok = 1; en = 1; seq_done = 1;
      step(1);
   endtask

   task automatic set_src(input int s, input logic v);
      if (s < 4) uv_flags[s] = v;
      else       od_stuck[s-4] = v;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      step(2);
      chk("R9 reset status", fault_latched, 0);
      chk("R5 reset shut_main with en low", shut_main, 1);
      chk("R6 reset shut_logic", shut_logic, 0);
      chk("R3 reset timer", tmr_value, 0);
      rst_n = 1;
      step(1);

      // R2 R3 R10 duration sweep over every timed source
      for (int s = 0; s < 6; s++) begin
         for (int d = 1; d <= TMO + 1; d++) begin
            int kind;
            int lat;
            kind = (s == 3) ? 2 : 1;
            lat  = (d >= TMO) ? kind : 0;
            restart();
            set_src(s, 1);
            step(d);
            chk("R2 timer during episode", tmr_value, (d < TMO) ? d : 0);
            chk("R9 status after episode", fault_latched, lat);
            chk("R2 shut_main after episode", shut_main, (d >= TMO) ? 1 : 0);
            chk("R6 shut_logic after episode", shut_logic, (d >= TMO && s == 3) ? 1 : 0);
            set_src(s, 0);
            step(1);
            chk("R3 timer idle after clear", tmr_value, 0);
            chk("R3 latch unchanged after clear", fault_latched, lat);
            if (lat != 0) begin
               en = 0;
               step(1);
               chk("R5 R6 latch after enable low", fault_latched, (s == 3) ? 2 : 0);
               chk("R6 shut_logic after enable low", shut_logic, (s == 3) ? 1 : 0);
               chk("R5 shut_main with enable low", shut_main, 1);
               en = 1;
               step(1);
               chk("R5 shut_main after re-enable", shut_main, (s == 3) ? 1 : 0);
               supply_ok = 0;
               step(1);
               chk("R7 supply drop clears", fault_latched, 0);
               chk("R7 supply drop clears shut_logic", shut_logic, 0);
            end
         end
      end

      // R1 immediate sources
      for (int i = 0; i < 3; i++) begin
         restart();
         if (i == 0) dly_fault = 1;
         if (i == 1) ref_fault = 1;
         if (i == 2) ot_fault = 1;
         step(1);
         chk("R1 immediate latch", fault_latched, 1);
         chk("R1 immediate shut_main", shut_main, 1);
         chk("R1 no timer on immediate", tmr_value, 0);
         clear_inputs();
         step(2);
         chk("R1 immediate latch holds", fault_latched, 1);
         // R4 ignored before start-up completes
         restart();
         seq_done = 0;
         if (i == 0) dly_fault = 1;
         if (i == 1) ref_fault = 1;
         if (i == 2) ot_fault = 1;
         uv_flags = 4'hF; od_stuck = 2'b11;
         step(TMO + 3);
         chk("R4 no latch without seq_done", fault_latched, 0);
         chk("R4 timer idle without seq_done", tmr_value, 0);
         chk("R4 shut_main low without seq_done", shut_main, 0);
      end

      // R8 overlapping episode with short logic pulse
      restart();
      uv_flags[0] = 1;
      step(2);
      uv_flags[3] = 1;
      step(1);
      chk("R8 shared timer", tmr_value, 3);
      uv_flags[3] = 0;
      step(TMO - 3);
      chk("R8 worst latch kind", fault_latched, 2);
      chk("R8 logic rail off", shut_logic, 1);

      // R8 without logic: boost and negative overlap, enable kind
      restart();
      uv_flags[0] = 1;
      step(2);
      uv_flags[2] = 1;
      uv_flags[0] = 0;
      step(TMO - 2);
      chk("R8 overlap enable kind", fault_latched, 1);

      // R3 new episode restarts the count
      restart();
      uv_flags[0] = 1;
      step(3);
      uv_flags[0] = 0;
      step(1);
      chk("R3 gap resets timer", tmr_value, 0);
      uv_flags[1] = 1;
      step(TMO - 1);
      chk("R3 restarted count", tmr_value, TMO - 1);
      chk("R3 no early latch", fault_latched, 0);
      step(1);
      chk("R2 latch at limit", fault_latched, 1);

      // R10 enable low masks main faults, logic still watched
      restart();
      en = 0;
      uv_flags[0] = 1; od_stuck[1] = 1;
      step(TMO + 2);
      chk("R10 main faults ignored with en low", fault_latched, 0);
      chk("R10 timer idle with en low", tmr_value, 0);
      chk("R6 shut_logic not from enable", shut_logic, 0);
      uv_flags[3] = 1;
      step(TMO);
      chk("R10 logic watched with en low", fault_latched, 2);
      chk("R6 logic latched", shut_logic, 1);
      en = 1;
      clear_inputs();
      step(2);
      chk("R6 enable toggle keeps logic latch", fault_latched, 2);
      chk("R6 shut_main held by logic latch", shut_main, 1);
      supply_ok = 0;
      step(1);
      chk("R7 supply drop releases logic", fault_latched, 0);

      finish_run();
   end
endmodule